// File: doc/BRIEF.md
# Dual-Period Heartbeat Watchdog

This block supervises a processor by watching a single heartbeat wire that software toggles. Any change of level, whether rising or falling, proves the processor is alive and restarts the supervision window. A level held too long without a change drives the active-low fault flag low. The fault flag is meant to raise an interrupt or to be looped back into the system reset logic.

Every reset event arms a long first window, so a slow boot can finish before routine supervision starts. The block moves to a short routine window either at the first heartbeat change or when the long window runs out, whichever comes first. While the system is held in reset, the counter stays cleared and the fault flag stays high. Counting resumes in the long window once the reset-active input drops.

All timing counts pulses of a prescaled tick enable. Both window lengths are parameters given in ticks. The heartbeat is asynchronous and passes through a two-flop synchronizer. Because of that synchronizer, a level change reaches the outputs on the third rising clock edge after it arrives.

Top module: `hb_watchdog`

## Requirements
- R1: While `rst_n` is sampled low, `fault_n` is 1 and `long_mode` is 1 on the following cycle.
- R2: After a reset with no heartbeat change, `fault_n` stays 1 and `long_mode` stays 1 for the first LONG_TICKS-1 counted ticks.
- R3: A heartbeat change seen during the long window sets `long_mode` to 0 and restarts the count. The next fault then comes SHORT_TICKS ticks later, not at the end of the long window.
- R4: With `long_mode` at 0, `fault_n` goes to 0 on the SHORT_TICKS-th counted tick after the last heartbeat change, if no further change arrives.
- R5: Rising and falling heartbeat changes are equally valid. A change on `heartbeat` between clock edges takes effect on the outputs at the third rising edge after it.
- R6: If the long window expires without a heartbeat change, `fault_n` goes to 0 on the LONG_TICKS-th counted tick and `long_mode` goes to 0 in the same cycle.
- R7: Once `fault_n` is 0, it stays 0 until a heartbeat change. That change sets `fault_n` to 1 and starts a short window.
- R8: A heartbeat change that takes effect in the same cycle as a window expiry counts as a valid update: `fault_n` stays 1.
- R9: While `reset_event` or `reset_active` is 1, the next cycle shows `fault_n`=1 and `long_mode`=1 with the count cleared. Heartbeat changes during this time are ignored. Once both inputs are 0, a full long window of LONG_TICKS ticks runs again.
- R10: The count advances only in cycles where `tick_en` is 1. With `tick_en` held at 0, no fault is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled tick; one count per cycle in which it is high |
| reset_event | input | 1 | Synchronous reset-event strobe (power-up, brownout, manual) |
| reset_active | input | 1 | High while the system reset is still being asserted |
| heartbeat | input | 1 | Asynchronous processor heartbeat; either level change is a valid update |
| fault_n | output | 1 | Active-low watchdog fault flag |
| long_mode | output | 1 | 1 while the long initial window is in force |

## Verification
The assertions assume three things about the inputs: `tick_en`, `reset_event` and `reset_active` are synchronous to `clk`, and the heartbeat is held at 0 during `rst_n`. Under those conditions the synchronizer never presents a spurious level change after reset. The stimulus drives every input half a cycle away from the sampling edge. It keeps the heartbeat low throughout the power-on reset, and it toggles the heartbeat inside a hold period only early enough for the delayed copy to settle before release. Each expected output is placed on an absolute cycle number worked out from the three-edge heartbeat latency and the tick count.

// File: rtl/hbw_pkg.sv
// Shared types for the dual-period heartbeat watchdog.
package hbw_pkg;
    // Active supervision window.
    typedef enum logic {
        WIN_SHORT = 1'b0,
        WIN_LONG  = 1'b1
    } win_mode_e;
endpackage

// File: rtl/hbw_edge_detect.sv
// Synchronizes an asynchronous level and flags each change of it.
// Assumes: async_in may change at any time; edge_pulse is high for exactly
// one clock per settled level change, SYNC_STAGES+1 edges of latency total.
module hbw_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_pulse
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] pipe_q;

    // Shift chain: SYNC_STAGES synchronizer flops plus one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[LAST-1:0], async_in};
        end
    end

    // A change shows up as a difference between the synchronized value and its copy.
    always_comb begin
        edge_pulse = pipe_q[LAST] ^ pipe_q[LAST-1];
    end
endmodule

// File: rtl/hbw_window_ctrl.sv
// Window counter and fault/mode state for the heartbeat watchdog.
// Assumes: hold, tick_en and hb_edge are synchronous; LONG_TICKS > SHORT_TICKS >= 2.
module hbw_window_ctrl
    import hbw_pkg::*;
#(
    parameter int LONG_TICKS  = 35000,
    parameter int SHORT_TICKS = 1120,
    localparam int CW = $clog2(LONG_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          hold,
    input  logic          hb_edge,
    output logic          fault_n,
    output win_mode_e     mode,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          fault_n_q;
    win_mode_e     mode_q;
    logic [CW-1:0] last_q;
    logic          expire;

    // Pick the terminal count of the active window and detect its final tick.
    always_comb begin
        last_q = (mode_q == WIN_LONG) ? LONG_LAST : SHORT_LAST;
        expire = tick_en && fault_n_q && (cnt_q == last_q);
    end

    // Window sequencing: hold clears, edge restarts short, expiry raises the fault.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q     <= '0;
            fault_n_q <= 1'b1;
            mode_q    <= WIN_LONG;
        end else if (hb_edge) begin
            cnt_q     <= '0;
            fault_n_q <= 1'b1;
            mode_q    <= WIN_SHORT;
        end else if (!fault_n_q) begin
            cnt_q     <= '0;
        end else if (expire) begin
            cnt_q     <= '0;
            fault_n_q <= 1'b0;
            mode_q    <= WIN_SHORT;
        end else if (tick_en) begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    assign fault_n = fault_n_q;
    assign mode    = mode_q;
    assign cnt     = cnt_q;
endmodule

// File: rtl/hb_watchdog.sv
// Dual-period heartbeat watchdog: long first window after any reset, short
// routine window afterwards, restarted by either heartbeat polarity.
// Assumes: all inputs except heartbeat are synchronous to clk.
module hb_watchdog
    import hbw_pkg::*;
#(
    parameter int LONG_TICKS  = 35000,
    parameter int SHORT_TICKS = 1120,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic reset_event,
    input  logic reset_active,
    input  logic heartbeat,
    output logic fault_n,
    output logic long_mode
);
    localparam int CW = $clog2(LONG_TICKS + 1);

    logic          hb_edge_w;
    logic          hold_w;
    win_mode_e     mode_w;
    logic [CW-1:0] cnt_w;

    // Either reset source freezes and clears the supervision.
    always_comb begin
        hold_w = reset_event | reset_active;
    end

    hbw_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (heartbeat),
        .edge_pulse (hb_edge_w)
    );

    hbw_window_ctrl #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .hold    (hold_w),
        .hb_edge (hb_edge_w),
        .fault_n (fault_n),
        .mode    (mode_w),
        .cnt     (cnt_w)
    );

    assign long_mode = (mode_w == WIN_LONG);
endmodule

// File: rtl/hbw_checker.sv
// Temporal checks for hb_watchdog, attached by bind.
module hbw_checker #(
    parameter int LONG_TICKS  = 35000,
    parameter int SHORT_TICKS = 1120,
    localparam int CW = $clog2(LONG_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          reset_event,
    input logic          reset_active,
    input logic          hb_edge,
    input logic          fault_n,
    input logic          long_mode,
    input logic [CW-1:0] cnt
);
    a_r9_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_event || reset_active) |=> (fault_n && long_mode && cnt == '0));

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !hb_edge && !reset_event && !reset_active) |=> !fault_n);

    a_r10_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && !tick_en) |=> fault_n);

    a_r5_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_edge && !reset_event && !reset_active) |=> (fault_n && !long_mode && cnt == '0));

    a_r4_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < (long_mode ? LONG_TICKS : SHORT_TICKS));

    a_r3_leave_long: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(long_mode) |-> ($past(hb_edge) || $fell(fault_n)));
endmodule

bind hb_watchdog hbw_checker #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .reset_event  (reset_event),
    .reset_active (reset_active),
    .hb_edge      (hb_edge_w),
    .fault_n      (fault_n),
    .long_mode    (long_mode),
    .cnt          (cnt_w)
);

// File: tb/hb_watchdog_bench.sv
// Scoreboard bench: scenario tasks queue expected outputs by cycle number,
// a negedge monitor pops and compares them.
module hb_watchdog_bench;
    localparam int L = 20;
    localparam int S = 6;

    typedef struct {
        int    at;
        bit    f;
        bit    m;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic reset_event = 1'b0;
    logic reset_active = 1'b0;
    logic heartbeat = 1'b0;
    logic fault_n;
    logic long_mode;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    hb_watchdog #(.LONG_TICKS(L), .SHORT_TICKS(S)) u_hb_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .reset_event  (reset_event),
        .reset_active (reset_active),
        .heartbeat    (heartbeat),
        .fault_n      (fault_n),
        .long_mode    (long_mode)
    );

    // Driver side: insert an expectation in cycle order.
    task automatic expect_at(input int at, input bit f, input bit m, input string req);
        exp_t it;
        int   i = 0;
        it.at = at; it.f = f; it.m = m; it.req = req;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, it);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: compare every expectation due in the current cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            n_tests++;
            if (it.at != cyc || fault_n !== it.f || long_mode !== it.m) begin
                n_fail++;
                $display("FAIL %s cycle %0d (due %0d): fault_n=%b long_mode=%b expected %b %b",
                         it.req, cyc, it.at, fault_n, long_mode, it.f, it.m);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int c;
        int d;
        int r;
        int q;
        int t;

        // R1: reset state
        step(3);
        expect_at(cyc + 1, 1'b1, 1'b1, "R1");
        step(2);

        // R2, R6: long window runs out without heartbeat; R7 fault persists
        c = cyc;
        rst_n = 1'b1;
        expect_at(c + L - 1, 1'b1, 1'b1, "R2");
        expect_at(c + L,     1'b0, 1'b0, "R6");
        expect_at(c + L + 5, 1'b0, 0, "R7");
        step(L + 6);

        // R7, R5, R4: rising change releases fault, then short window expires
        d = cyc;
        heartbeat = 1'b1;
        expect_at(d + 2,         1'b0, 1'b0, "R7");
        expect_at(d + 3,         1'b1, 1'b0, "R7");
        expect_at(d + 3 + S - 1, 1'b1, 1'b0, "R4");
        expect_at(d + 3 + S,     1'b0, 1'b0, "R4");
        step(S + 6);

        // R9 strobe, R3: first change during long window selects short window
        c = cyc;
        reset_event = 1'b1;
        expect_at(c + 1, 1'b1, 1'b1, "R9");
        expect_at(c + 5, 1'b1, 1'b1, "R3");
        expect_at(c + 6, 1'b1, 1'b0, "R3");
        expect_at(c + 6 + S - 1, 1'b1, 1'b0, "R3");
        expect_at(c + 6 + S,     1'b0, 1'b0, "R3");
        step(1);
        reset_event = 1'b0;
        step(2);
        heartbeat = 1'b0;
        step(S + 8);

        // R5: alternating rising and falling changes keep the flag high
        d = cyc;
        for (int i = 0; i < 6; i++) begin
            d = cyc;
            heartbeat = ~heartbeat;
            expect_at(d + 3, 1'b1, 1'b0, "R5");
            expect_at(d + 4, 1'b1, 1'b0, "R5");
            step(4);
        end

        // R8: each change lands exactly on the expiry cycle
        step(S - 4);
        for (int i = 0; i < 4; i++) begin
            d = cyc;
            heartbeat = ~heartbeat;
            expect_at(d + 3, 1'b1, 1'b0, "R8");
            step(S);
        end
        expect_at(d + 3 + S, 1'b0, 1'b0, "R4");
        step(5);

        // R9: reset-active hold clears the fault and ignores heartbeat
        r = cyc;
        reset_active = 1'b1;
        expect_at(r + 1, 1'b1, 1'b1, "R9");
        expect_at(r + 5, 1'b1, 1'b1, "R9");
        expect_at(r + L + 10, 1'b1, 1'b1, "R9");
        step(2);
        heartbeat = ~heartbeat;
        step(L + 10);
        q = cyc;
        reset_active = 1'b0;
        expect_at(q + L - 1, 1'b1, 1'b1, "R9");
        expect_at(q + L,     1'b0, 1'b0, "R9");
        step(L + 3);

        // R10: no ticks means no count; sparse ticks stretch the window
        c = cyc;
        reset_event = 1'b1;
        tick_en = 1'b0;
        expect_at(c + 1, 1'b1, 1'b1, "R10");
        expect_at(c + 40, 1'b1, 1'b1, "R10");
        step(1);
        reset_event = 1'b0;
        step(40);
        t = cyc;
        expect_at(t + 2 * L - 2, 1'b1, 1'b1, "R10");
        expect_at(t + 2 * L - 1, 1'b0, 1'b0, "R10");
        for (int k = 0; k < 2 * L; k++) begin
            tick_en = (k % 2 == 0);
            step(1);
        end
        tick_en = 1'b1;
        step(5);

        // R1: synchronous reset in mid-run restores the idle state
        rst_n = 1'b0;
        expect_at(cyc + 1, 1'b1, 1'b1, "R1");
        step(3);

        done = 1'b1;
        finish_run();
    end
endmodule